// File: doc/BRIEF.md
# Descriptor Ring Memory Copy Engine

This block copies blocks of memory from one place to another under the control of two descriptor rings that live in shared memory. Each slot of the source ring names where to read and how many bytes to move. The slot at the same index of the destination ring names where to write. Both rings share one hardware walk index. Software fills slots, then advances its own index on the source ring. The engine works through every slot from its hardware index up to, but not including, the software index. For each slot it reads the payload in 32-bit words, writes them out, and marks the destination descriptor as done.

The destination ring keeps one slot free. Its software index names the last slot that software has taken back, and the engine never writes the slot at that index. A control register holds the enables, the busy flags and a few mode bits. A soft-reset register clears the walk indices and abandons any copy in progress. The memory side is one request channel with valid/ready handshake and one read-response channel.

On the request channel, the engine holds valid, address, write flag and data steady until ready is seen. Each accepted read is answered by exactly one beat on the response channel, at any later cycle. The response channel has no back-pressure: the engine is always waiting for that beat when it comes.

Top module: `rcopy_top`

## Requirements
- R1: After reset every register reads zero, busy is clear, done_pulse is low and no memory request is made.
- R2: Registers sit at these byte offsets, and each written value reads back unchanged:
  - source ring: base 0x000, slot count 0x004, software index 0x008, hardware index 0x00C;
  - destination ring: the same four registers at 0x100 to 0x10C;
  - control register at 0x204;
  - reset register at 0x208.
- R3: The engine walks the slots from the hardware index up to, but not including, the source software index, one slot at a time. It advances both hardware indices by one after each slot.
- R4: A descriptor is four 32-bit words, 16 bytes per slot. Word 0 holds the address. Word 1 bits 29:16 hold the byte length. The engine moves ceil(len/4) words, with len clamped to 0x3F80, and writes no word past that count.
- R5: After the last payload write of a slot, the engine writes destination word 1 as the done bit plus the clamped length in bits 29:16. The done bit is bit 31 by default, or bit 15 when DONE_HI=0. It then raises done_pulse for exactly one cycle.
- R6: The engine never starts a slot whose index equals the destination software index. It stays idle until software moves that index away.
- R7: Control bit 0 enables the source side and bit 2 enables the destination side. If either is cleared, the engine completes the slot in progress, starts no new one, and drops busy. Busy reads on bits 1 and 3.
- R8: Reset register bit 0 clears the source hardware index and bit 16 clears the destination hardware index. While either bit is set, any copy in progress is abandoned, busy drops the next cycle, and the descriptor of the abandoned slot is not marked done.
- R9: A memory request stays valid with stable address, write flag and data until ready is seen. Copies complete correctly under back-pressure.
- R10: With control bit 6 (done write-back) clear, the payload is still copied and the index still advances. Destination word 1 is not written and no done_pulse is raised.
- R11: Index arithmetic wraps modulo the slot count, which must be a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address, word aligned |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data beat valid |
| mem_rsp_rdata | input | 32 | Read data |
| done_pulse | output | 1 | One-cycle pulse per completed write-back |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, an index field sized for rings of up to 64 slots, and the done flag at bit 31. It programs a slot count of 4. That small ring lets a handful of descriptors reach the index wrap and the one-empty-slot guard. The default clamp of 0x3F80 bytes is exercised with an oversized length. Back-pressure comes from a ready signal that stalls one cycle in four.

// File: rtl/rcopy_pkg.sv
package rcopy_pkg;

  localparam logic [11:0] OFF_SRC_BASE  = 12'h000;
  localparam logic [11:0] OFF_SRC_COUNT = 12'h004;
  localparam logic [11:0] OFF_SRC_SWIDX = 12'h008;
  localparam logic [11:0] OFF_SRC_HWIDX = 12'h00C;
  localparam logic [11:0] OFF_DST_BASE  = 12'h100;
  localparam logic [11:0] OFF_DST_COUNT = 12'h104;
  localparam logic [11:0] OFF_DST_SWIDX = 12'h108;
  localparam logic [11:0] OFF_DST_HWIDX = 12'h10C;
  localparam logic [11:0] OFF_CTRL      = 12'h204;
  localparam logic [11:0] OFF_SRST      = 12'h208;

  localparam int CB_SRC_EN   = 0;
  localparam int CB_SRC_BUSY = 1;
  localparam int CB_DST_EN   = 2;
  localparam int CB_DST_BUSY = 3;
  localparam int CB_BURST_LO = 4;
  localparam int CB_WB_EN    = 6;
  localparam int CB_MULTI    = 10;

  localparam int SR_SRC = 0;
  localparam int SR_DST = 16;

  localparam logic [13:0] SEG_MAX_BYTES = 14'h3F80;
  localparam int          LEN_LSB       = 16;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SA_REQ, ST_SA_WAIT, ST_SL_REQ, ST_SL_WAIT,
    ST_DA_REQ, ST_DA_WAIT, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ,
    ST_WB_REQ, ST_NEXT
  } eng_state_e;

  function automatic int done_pos(bit hi);
    return hi ? 31 : 15;
  endfunction

  function automatic int last_pos(bit hi);
    return hi ? 30 : 14;
  endfunction

endpackage

// File: rtl/rcopy_regs.sv
module rcopy_regs
  import rcopy_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              adv,
  output logic [ADDR_W-1:0] src_base,
  output logic [ADDR_W-1:0] dst_base,
  output logic [IDX_W-1:0]  src_mask,
  output logic [IDX_W-1:0]  hw_idx,
  output logic [IDX_W-1:0]  src_sw,
  output logic [IDX_W-1:0]  dst_sw,
  output logic              src_en,
  output logic              dst_en,
  output logic              wb_en,
  output logic              abort
);

  localparam int CNT_W = IDX_W + 1;

  logic [CNT_W-1:0] src_cnt_q, dst_cnt_q;
  logic [IDX_W-1:0] src_hw_q, dst_hw_q, dst_mask;
  logic [1:0]       burst_q;
  logic             multi_q, srst_src_q, srst_dst_q;

  assign src_mask = IDX_W'(src_cnt_q - 1'b1);
  assign dst_mask = IDX_W'(dst_cnt_q - 1'b1);
  assign hw_idx   = src_hw_q;
  assign abort    = srst_src_q | srst_dst_q;

  function automatic logic hit(input logic [11:0] a, input logic [11:0] off);
    return a == off;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_base   <= '0;
      dst_base   <= '0;
      src_cnt_q  <= '0;
      dst_cnt_q  <= '0;
      src_sw     <= '0;
      dst_sw     <= '0;
      src_en     <= 1'b0;
      dst_en     <= 1'b0;
      wb_en      <= 1'b0;
      burst_q    <= '0;
      multi_q    <= 1'b0;
      srst_src_q <= 1'b0;
      srst_dst_q <= 1'b0;
    end else if (reg_we) begin
      if (hit(reg_addr, OFF_SRC_BASE))  src_base  <= ADDR_W'(reg_wdata);
      if (hit(reg_addr, OFF_DST_BASE))  dst_base  <= ADDR_W'(reg_wdata);
      if (hit(reg_addr, OFF_SRC_COUNT)) src_cnt_q <= CNT_W'(reg_wdata);
      if (hit(reg_addr, OFF_DST_COUNT)) dst_cnt_q <= CNT_W'(reg_wdata);
      if (hit(reg_addr, OFF_SRC_SWIDX)) src_sw    <= IDX_W'(reg_wdata) & src_mask;
      if (hit(reg_addr, OFF_DST_SWIDX)) dst_sw    <= IDX_W'(reg_wdata) & dst_mask;
      if (hit(reg_addr, OFF_CTRL)) begin
        src_en  <= reg_wdata[CB_SRC_EN];
        dst_en  <= reg_wdata[CB_DST_EN];
        burst_q <= reg_wdata[CB_BURST_LO +: 2];
        wb_en   <= reg_wdata[CB_WB_EN];
        multi_q <= reg_wdata[CB_MULTI];
      end
      if (hit(reg_addr, OFF_SRST)) begin
        srst_src_q <= reg_wdata[SR_SRC];
        srst_dst_q <= reg_wdata[SR_DST];
      end
    end
  end

  // Hardware indices: reset bit wins, then engine advance, then software write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_hw_q <= '0;
      dst_hw_q <= '0;
    end else begin
      if (srst_src_q)                                  src_hw_q <= '0;
      else if (adv)                                    src_hw_q <= (src_hw_q + 1'b1) & src_mask;
      else if (reg_we && hit(reg_addr, OFF_SRC_HWIDX)) src_hw_q <= IDX_W'(reg_wdata) & src_mask;
      if (srst_dst_q)                                  dst_hw_q <= '0;
      else if (adv)                                    dst_hw_q <= (dst_hw_q + 1'b1) & dst_mask;
      else if (reg_we && hit(reg_addr, OFF_DST_HWIDX)) dst_hw_q <= IDX_W'(reg_wdata) & dst_mask;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFF_SRC_BASE:  reg_rdata = 32'(src_base);
      OFF_SRC_COUNT: reg_rdata = 32'(src_cnt_q);
      OFF_SRC_SWIDX: reg_rdata = 32'(src_sw);
      OFF_SRC_HWIDX: reg_rdata = 32'(src_hw_q);
      OFF_DST_BASE:  reg_rdata = 32'(dst_base);
      OFF_DST_COUNT: reg_rdata = 32'(dst_cnt_q);
      OFF_DST_SWIDX: reg_rdata = 32'(dst_sw);
      OFF_DST_HWIDX: reg_rdata = 32'(dst_hw_q);
      OFF_CTRL: begin
        reg_rdata[CB_SRC_EN]         = src_en;
        reg_rdata[CB_SRC_BUSY]       = busy;
        reg_rdata[CB_DST_EN]         = dst_en;
        reg_rdata[CB_DST_BUSY]       = busy;
        reg_rdata[CB_BURST_LO +: 2]  = burst_q;
        reg_rdata[CB_WB_EN]          = wb_en;
        reg_rdata[CB_MULTI]          = multi_q;
      end
      OFF_SRST: begin
        reg_rdata[SR_SRC] = srst_src_q;
        reg_rdata[SR_DST] = srst_dst_q;
      end
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rcopy_engine.sv
module rcopy_engine
  import rcopy_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 6,
  parameter bit DONE_HI = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [IDX_W-1:0]  hw_idx,
  input  logic [IDX_W-1:0]  src_sw,
  input  logic [IDX_W-1:0]  dst_sw,
  input  logic              src_en,
  input  logic              dst_en,
  input  logic              wb_en,
  input  logic              abort,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata,
  output logic              busy,
  output logic              adv,
  output logic              done_pulse
);

  localparam int DONE_BIT = done_pos(DONE_HI);
  localparam int WCNT_W   = 13;

  eng_state_e         st_q;
  logic [IDX_W-1:0]   idx_q;
  logic [ADDR_W-1:0]  sptr_q, dptr_q, off_q;
  logic [13:0]        len_q;
  logic [WCNT_W-1:0]  words_q;
  logic [31:0]        data_q;
  logic               wbd_q;

  logic               start;
  logic [ADDR_W-1:0]  slot_off, sdesc, ddesc;
  logic [13:0]        len_raw, len_clamped;
  logic [WCNT_W-1:0]  words_new;
  logic [31:0]        wb_word;

  assign start       = src_en && dst_en && !abort && (hw_idx != src_sw) && (hw_idx != dst_sw);
  assign slot_off    = ADDR_W'(idx_q) << 4;
  assign sdesc       = src_base + slot_off;
  assign ddesc       = dst_base + slot_off;
  assign len_raw     = mem_rsp_rdata[LEN_LSB +: 14];
  assign len_clamped = (len_raw > SEG_MAX_BYTES) ? SEG_MAX_BYTES : len_raw;
  assign words_new   = WCNT_W'(({1'b0, len_clamped} + 15'd3) >> 2);

  always_comb begin
    wb_word = '0;
    wb_word[LEN_LSB +: 14] = len_q;
    wb_word[DONE_BIT]      = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      sptr_q  <= '0;
      dptr_q  <= '0;
      off_q   <= '0;
      len_q   <= '0;
      words_q <= '0;
      data_q  <= '0;
      wbd_q   <= 1'b0;
    end else if (abort) begin
      st_q  <= ST_IDLE;
      wbd_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          idx_q <= hw_idx;
          wbd_q <= 1'b0;
          st_q  <= ST_SA_REQ;
        end
        ST_SA_REQ:  if (mem_req_ready) st_q <= ST_SA_WAIT;
        ST_SA_WAIT: if (mem_rsp_valid) begin
          sptr_q <= ADDR_W'(mem_rsp_rdata);
          st_q   <= ST_SL_REQ;
        end
        ST_SL_REQ:  if (mem_req_ready) st_q <= ST_SL_WAIT;
        ST_SL_WAIT: if (mem_rsp_valid) begin
          len_q   <= len_clamped;
          words_q <= words_new;
          st_q    <= ST_DA_REQ;
        end
        ST_DA_REQ:  if (mem_req_ready) st_q <= ST_DA_WAIT;
        ST_DA_WAIT: if (mem_rsp_valid) begin
          dptr_q <= ADDR_W'(mem_rsp_rdata);
          off_q  <= '0;
          if (words_q != '0) st_q <= ST_RD_REQ;
          else               st_q <= wb_en ? ST_WB_REQ : ST_NEXT;
        end
        ST_RD_REQ:  if (mem_req_ready) st_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rsp_valid) begin
          data_q <= mem_rsp_rdata;
          st_q   <= ST_WR_REQ;
        end
        ST_WR_REQ:  if (mem_req_ready) begin
          off_q   <= off_q + ADDR_W'(4);
          words_q <= words_q - 1'b1;
          if (words_q == WCNT_W'(1)) st_q <= wb_en ? ST_WB_REQ : ST_NEXT;
          else                       st_q <= ST_RD_REQ;
        end
        ST_WB_REQ:  if (mem_req_ready) begin
          wbd_q <= 1'b1;
          st_q  <= ST_NEXT;
        end
        ST_NEXT:    st_q <= ST_IDLE;
        default:    st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    unique case (st_q)
      ST_SA_REQ: begin mem_req_valid = 1'b1; mem_req_addr = sdesc; end
      ST_SL_REQ: begin mem_req_valid = 1'b1; mem_req_addr = sdesc + ADDR_W'(4); end
      ST_DA_REQ: begin mem_req_valid = 1'b1; mem_req_addr = ddesc; end
      ST_RD_REQ: begin mem_req_valid = 1'b1; mem_req_addr = sptr_q + off_q; end
      ST_WR_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = dptr_q + off_q;
        mem_req_wdata = data_q;
      end
      ST_WB_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = ddesc + ADDR_W'(4);
        mem_req_wdata = wb_word;
      end
      default: ;
    endcase
  end

  assign busy       = (st_q != ST_IDLE);
  assign adv        = (st_q == ST_NEXT);
  assign done_pulse = (st_q == ST_NEXT) && wbd_q;

endmodule

// File: rtl/rcopy_top.sv
module rcopy_top #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 6,
  parameter bit DONE_HI = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata,
  output logic              done_pulse
);

  logic [ADDR_W-1:0] src_base, dst_base;
  logic [IDX_W-1:0]  src_mask, hw_idx, src_sw, dst_sw;
  logic              src_en, dst_en, wb_en, abort, eng_busy, eng_adv;

  rcopy_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(eng_busy), .adv(eng_adv),
    .src_base(src_base), .dst_base(dst_base), .src_mask(src_mask),
    .hw_idx(hw_idx), .src_sw(src_sw), .dst_sw(dst_sw),
    .src_en(src_en), .dst_en(dst_en), .wb_en(wb_en), .abort(abort)
  );

  rcopy_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DONE_HI(DONE_HI)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .src_base(src_base), .dst_base(dst_base),
    .hw_idx(hw_idx), .src_sw(src_sw), .dst_sw(dst_sw),
    .src_en(src_en), .dst_en(dst_en), .wb_en(wb_en), .abort(abort),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .busy(eng_busy), .adv(eng_adv), .done_pulse(done_pulse)
  );

endmodule

// File: rtl/rcopy_checker.sv
module rcopy_checker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [31:0]       mem_req_wdata,
  input logic              done_pulse,
  input logic              busy,
  input logic              adv,
  input logic              abort,
  input logic              src_en,
  input logic [IDX_W-1:0]  hw_idx,
  input logic [IDX_W-1:0]  src_mask,
  input logic [IDX_W-1:0]  dst_sw
);

  logic [IDX_W-1:0] nxt_idx;
  assign nxt_idx = (hw_idx + 1'b1) & src_mask;

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !abort) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);

  p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !abort) |=> (hw_idx == $past(nxt_idx)));

  p_slot_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(hw_idx) != $past(dst_sw)));

  p_stay_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !src_en) |=> !busy);

endmodule

bind rcopy_top rcopy_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .done_pulse(done_pulse),
  .busy(eng_busy), .adv(eng_adv), .abort(abort), .src_en(src_en),
  .hw_idx(hw_idx), .src_mask(src_mask), .dst_sw(dst_sw)
);

// File: tb/rcopy_top_tb_top.sv
module rcopy_top_tb_top;

  localparam logic [11:0] A_SBASE = 12'h000, A_SCNT = 12'h004, A_SSW = 12'h008, A_SHW = 12'h00C;
  localparam logic [11:0] A_DBASE = 12'h100, A_DCNT = 12'h104, A_DSW = 12'h108, A_DHW = 12'h10C;
  localparam logic [11:0] A_CTRL  = 12'h204, A_SRST = 12'h208;
  localparam int DST_RING = 32'h100;
  localparam logic [31:0] SENT = 32'hDEADBEEF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_rdata = '0;
  logic done_pulse;
  logic stall_en = 1'b0;
  logic [1:0] stall_cnt = '0;
  logic [31:0] mem [0:16383];
  int errors = 0, checks = 0, done_cnt = 0;

  always #5 clk = ~clk;

  rcopy_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .done_pulse(done_pulse)
  );

  assign mem_req_ready = stall_en ? (stall_cnt != 2'd0) : 1'b1;

  always @(posedge clk) begin
    stall_cnt <= stall_cnt + 1'b1;
    mem_rsp_valid <= 1'b0;
    if (rst_n && done_pulse) done_cnt <= done_cnt + 1;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) mem[mem_req_addr[15:2]] = mem_req_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem[mem_req_addr[15:2]];
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'h5A000000 ^ (32'(i) * 32'h00010203) ^ 32'h00C0FFEE;
  endfunction

  task automatic put_desc(input int idx, input int src, input int dst, input int len, input int seed);
    int words = (len + 3) / 4;
    mem[(idx * 16) >> 2]     = 32'(src);
    mem[((idx * 16) >> 2) + 1] = (32'(len) << 16) | 32'h40000000;
    mem[(DST_RING + idx * 16) >> 2]     = 32'(dst);
    mem[((DST_RING + idx * 16) >> 2) + 1] = 32'h0;
    for (int w = 0; w < words + 1; w++) begin
      mem[(src >> 2) + w] = pat(seed + w);
      mem[(dst >> 2) + w] = SENT;
    end
  endtask

  task automatic wait_idx(input logic [31:0] target, input string req);
    logic [31:0] v, c;
    int n = 0;
    do begin
      rd(A_SHW, v);
      rd(A_CTRL, c);
      n++;
    end while (!(v == target && c[1] == 1'b0) && n < 15000);
    check(v == target, req, v, target);
  endtask

  task automatic check_copy(input int src, input int dst, input int nwords, input string req);
    int bad = 0;
    for (int w = 0; w < nwords; w++) if (mem[(dst >> 2) + w] !== mem[(src >> 2) + w]) bad++;
    check(bad == 0, req, 32'(bad), 32'h0);
    check(mem[(dst >> 2) + nwords] === SENT, req, mem[(dst >> 2) + nwords], SENT);
  endtask

  function automatic logic [31:0] dword1(input int idx);
    return mem[((DST_RING + idx * 16) >> 2) + 1];
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    rd(A_SCNT, v); check(v == 0, "R1 count", v, 0);
    rd(A_DSW, v);  check(v == 0, "R1 dst sw", v, 0);
    rd(A_CTRL, v); check(v == 0, "R1 ctrl", v, 0);
    check(!done_pulse && !mem_req_valid, "R1 outputs", {30'd0, done_pulse, mem_req_valid}, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    wr(A_SBASE, 32'h0);   wr(A_SCNT, 4); wr(A_SSW, 0); wr(A_SHW, 0);
    wr(A_DBASE, DST_RING); wr(A_DCNT, 4); wr(A_DSW, 3); wr(A_DHW, 0);
    rd(A_DBASE, v); check(v == DST_RING, "R2 dst base", v, DST_RING);
    rd(A_SCNT, v);  check(v == 4, "R2 src count", v, 4);
    rd(A_DSW, v);   check(v == 3, "R2 dst sw", v, 3);
    wr(A_CTRL, 32'h465);
    rd(A_CTRL, v);  check(v == 32'h465, "R2 ctrl", v, 32'h465);
  endtask

  task automatic t_single;
    int d0 = done_cnt;
    put_desc(0, 32'h1000, 32'h8000, 24, 1);
    wr(A_SSW, 1);
    wait_idx(1, "R3 advance");
    check_copy(32'h1000, 32'h8000, 6, "R4 copy 24B");
    check(dword1(0) == 32'h80180000, "R5 writeback", dword1(0), 32'h80180000);
    check(done_cnt - d0 == 1, "R5 pulse count", 32'(done_cnt - d0), 1);
  endtask

  task automatic t_round;
    put_desc(1, 32'h1200, 32'h8200, 10, 7);
    wr(A_SSW, 2);
    wait_idx(2, "R3 advance 2");
    check_copy(32'h1200, 32'h8200, 3, "R4 round up");
    check(dword1(1) == 32'h800A0000, "R5 len 10", dword1(1), 32'h800A0000);
  endtask

  task automatic t_guard_wrap;
    logic [31:0] v;
    put_desc(2, 32'h1300, 32'h8300, 8, 11);
    put_desc(3, 32'h1400, 32'h8400, 8, 13);
    wr(A_SSW, 0);
    wait_idx(3, "R6 stops before reclaimed slot");
    repeat (40) @(negedge clk);
    rd(A_SHW, v); check(v == 3, "R6 held", v, 3);
    check(dword1(3) == 0, "R6 slot untouched", dword1(3), 0);
    wr(A_DSW, 2);
    wait_idx(0, "R11 wrap to 0");
    check(dword1(3) == 32'h80080000, "R11 slot 3 done", dword1(3), 32'h80080000);
  endtask

  task automatic t_stall;
    stall_en = 1'b1;
    put_desc(0, 32'h1500, 32'h8500, 40, 17);
    wr(A_SSW, 1);
    wait_idx(1, "R9 advance under stall");
    check_copy(32'h1500, 32'h8500, 10, "R9 copy under stall");
    stall_en = 1'b0;
  endtask

  task automatic t_nowb;
    int d0 = done_cnt;
    wr(A_CTRL, 32'h25);
    put_desc(1, 32'h1600, 32'h8600, 8, 19);
    wr(A_SSW, 2);
    wait_idx(2, "R10 advance");
    check_copy(32'h1600, 32'h8600, 2, "R10 copy");
    check(dword1(1) == 0, "R10 no writeback", dword1(1), 0);
    check(done_cnt == d0, "R10 no pulse", 32'(done_cnt - d0), 0);
    wr(A_CTRL, 32'h65);
  endtask

  task automatic t_disable;
    logic [31:0] v;
    int n = 0;
    wr(A_DSW, 1);
    put_desc(2, 32'h1700, 32'h8700, 256, 23);
    put_desc(3, 32'h1900, 32'h8900, 8, 29);
    wr(A_SSW, 0);
    repeat (20) @(negedge clk);
    wr(A_CTRL, 32'h64);
    do begin rd(A_CTRL, v); n++; end while (v[1] && n < 5000);
    check(v[1] == 1'b0 && v[3] == 1'b0, "R7 busy drops", v, 32'h64);
    rd(A_SHW, v); check(v == 3, "R7 only current slot", v, 3);
    check_copy(32'h1700, 32'h8700, 64, "R7 current slot complete");
    check(dword1(3) == 0, "R7 next slot not started", dword1(3), 0);
    wr(A_CTRL, 32'h65);
    wait_idx(0, "R7 resume");
    check(dword1(3) == 32'h80080000, "R7 resumed slot", dword1(3), 32'h80080000);
  endtask

  task automatic t_clamp;
    put_desc(0, 32'h1000, 32'h8000, 32'h3FFF, 31);
    wr(A_SSW, 1);
    wait_idx(1, "R4 clamp advance");
    check_copy(32'h1000, 32'h8000, 32'h3F80 / 4, "R4 clamp 0x3F80");
    check(dword1(0) == 32'hBF800000, "R4 clamp len", dword1(0), 32'hBF800000);
  endtask

  task automatic t_abort;
    logic [31:0] v;
    wr(A_DSW, 0);
    put_desc(1, 32'h1200, 32'h8200, 400, 37);
    wr(A_SSW, 2);
    repeat (30) @(negedge clk);
    wr(A_SRST, 32'h00010001);
    rd(A_CTRL, v); check(v[1] == 1'b0, "R8 busy cleared", v, 32'h65);
    rd(A_SHW, v);  check(v == 0, "R8 src hw cleared", v, 0);
    rd(A_DHW, v);  check(v == 0, "R8 dst hw cleared", v, 0);
    check(dword1(1) == 0, "R8 no done mark", dword1(1), 0);
    wr(A_SRST, 0);
    repeat (40) @(negedge clk);
    rd(A_CTRL, v); check(v[1] == 1'b0, "R6 idle at reclaimed slot 0", v, 32'h65);
  endtask

  initial begin
    for (int i = 0; i < 16384; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_single();
    t_round();
    t_guard_wrap();
    t_stall();
    t_nowb();
    t_disable();
    t_clamp();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule